// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Loopback Routing and Receiver Wakeup

This block sends and receives asynchronous serial characters. Each character has one start bit, eight or nine data bits sent least significant bit first, and one stop bit. The block runs from a system clock and a baud tick that pulses at sixteen times the bit rate. The transmitter takes a parallel word with a valid/ready handshake. The receiver majority-votes three mid-bit samples and reports each character with a one-cycle valid pulse and a framing-error flag.

For self-test, the receiver can be cut off from its pin and fed straight from the transmit line. For single-wire networks, the receiver can instead listen on the sensed level of the transmit pad, with the pad driver enabled only while a character is going out.

In a multidrop network, a node can put its receiver into standby so that it ignores traffic addressed to other nodes. The receiver leaves standby in one of two ways, chosen by a control input:
- after a full character time of idle line, or
- on a character whose most significant data bit is 1 (an address mark).

Top module: `uart_loopwake`

## Requirements
- R1: After a synchronous active-low reset, tx_pin is 1, rx_valid, rx_ferr and rx_standby are 0, and tx_ready is 0 while tx_en is 0.
- R2: When tx_valid and tx_ready are both 1, the transmitter accepts tx_data and drives one start bit (0), the data bits least significant first, and one stop bit (1). Each bit lasts 16 baud ticks. tx_ready stays 0 until the frame ends.
- R3: When nine_bit is 1, both directions use nine data bits (tx_data[8:0], rx_data[8:0]). When nine_bit is 0, they use eight data bits, rx_data[8] reads 0 and tx_data[8] is not sent.
- R4: The receiver detects a 1-to-0 transition on its input and takes the majority of oversampling samples 7, 8 and 9 in each bit. It shows the character on rx_data together with a single-cycle rx_valid pulse.
- R5: If the stop bit is sampled as 0, rx_ferr is 1 in the same cycle as rx_valid, and the data is still delivered.
- R6: When loop_en is 1 and rx_src_ext is 0, the receiver is fed from the internal transmit line and rx_pin has no effect.
- R7: When loop_en is 1 and rx_src_ext is 1, the receiver is fed from wire_in. In this mode tx_oe is 0 while the transmitter is idle and 1 while it sends. In every other mode tx_oe is 1.
- R8: In either loop mode, if tx_en or rx_en is 0, the receiver input is held idle (1), so nothing is received from any pin.
- R9: A one-cycle pulse on rx_sleep_req sets rx_standby. While rx_standby is 1, characters that do not wake the receiver produce no rx_valid.
- R10: When wake_on_mark is 0, rx_standby clears once the receiver input has stayed 1 for a full character time after the sleep request: 10 bit times with eight data bits, 11 with nine.
- R11: When wake_on_mark is 1, an idle line does not clear rx_standby. A character whose most significant data bit is 1 (bit 7 with eight data bits, bit 8 with nine) is delivered and clears rx_standby in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| loop_en | input | 1 | Route the receiver away from rx_pin |
| rx_src_ext | input | 1 | In loop mode: 0 = internal transmit line, 1 = wire_in |
| nine_bit | input | 1 | 0 = eight data bits, 1 = nine data bits |
| wake_on_mark | input | 1 | 0 = idle-line wakeup, 1 = address-mark wakeup |
| rx_sleep_req | input | 1 | Pulse that puts the receiver into standby |
| tx_data | input | 9 | Word to transmit |
| tx_valid | input | 1 | tx_data is valid |
| tx_ready | output | 1 | Transmitter can accept a word |
| tx_pin | output | 1 | Serial transmit line, idle high |
| tx_oe | output | 1 | Transmit pad driver enable |
| wire_in | input | 1 | Sensed level of the transmit pad (single-wire mode) |
| rx_pin | input | 1 | Serial receive line |
| rx_data | output | 9 | Received character |
| rx_valid | output | 1 | One-cycle pulse: rx_data and rx_ferr are valid |
| rx_ferr | output | 1 | Stop bit of the character was sampled 0 |
| rx_standby | output | 1 | Receiver is in standby |

## Verification
The start bit appears on tx_pin one clock after the handshake. Each later bit follows 16 ticks (32 clocks on the bench) after the previous one, so the bench samples tx_pin 15.5 clocks after the load edge and then every 32 clocks. This keeps every sample at mid-bit whatever the tick phase.

rx_valid rises about 9.5 bit times after the start edge, on the clock after the tick that carries sample 9 of the stop bit. Because that exact cycle depends on the tick phase, a monitor checks every falling clock edge and compares each pulse against the queue of expected characters. Any pulse with no entry in the queue is a failure.

Standby changes are checked at points well clear of the edge of the idle window: just after a suppressed frame, when the line has been idle for only a fraction of a character, and again after twelve idle bit times.

// File: rtl/uart_lw_pkg.sv
// Package: shared types and helpers for the loop/wakeup transceiver.
// Assumes the oversampling factor is a power of two of at least 16.
package uart_lw_pkg;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_RECV = 1'b1
    } rx_state_t;

    // Majority of three samples.
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/uart_lw_tx.sv
// Module: transmitter. Serialises start, data (LSB first) and stop bits.
// Each bit lasts OVS baud ticks. The frame length is fixed when the word is
// loaded. Assumes tick is a single-cycle pulse.
module uart_lw_tx #(
    parameter int DATA_W = 9,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              en,
    input  logic              nine,
    input  logic [DATA_W-1:0] data,
    input  logic              valid,
    output logic              ready,
    output logic              line,
    output logic              busy
);
    localparam int FRAME_W = DATA_W + 2;
    localparam int CNT_W   = $clog2(OVS);
    localparam int BIT_W   = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] shreg;
    logic [BIT_W-1:0]   left;
    logic [CNT_W-1:0]   tcnt;
    logic               busy_q;

    // Load a frame on handshake, then shift one bit every OVS ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            busy_q <= 1'b0;
            shreg  <= '1;
            left   <= '0;
            tcnt   <= '0;
        end else if (!busy_q && valid) begin
            busy_q <= 1'b1;
            tcnt   <= '0;
            if (nine) begin
                shreg <= {1'b1, data, 1'b0};
                left  <= BIT_W'(FRAME_W);
            end else begin
                shreg <= {2'b11, data[DATA_W-2:0], 1'b0};
                left  <= BIT_W'(FRAME_W - 1);
            end
        end else if (busy_q && tick) begin
            if (tcnt == CNT_W'(OVS - 1)) begin
                tcnt  <= '0;
                shreg <= {1'b1, shreg[FRAME_W-1:1]};
                left  <= left - 1'b1;
                if (left == BIT_W'(1)) begin
                    busy_q <= 1'b0;
                end
            end else begin
                tcnt <= tcnt + 1'b1;
            end
        end
    end

    // Drive the line from the shifter while busy, otherwise idle high.
    always_comb begin
        line  = busy_q ? shreg[0] : 1'b1;
        ready = en && !busy_q;
        busy  = busy_q;
    end

    // R2: an accepted word drops ready on the next cycle.
    p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ready) |=> !ready);

    // R2: an accepted word puts a start bit on the line on the next cycle.
    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ready) |=> (line == 1'b0));

endmodule

// File: rtl/uart_lw_rx.sv
// Module: receiver. Finds a start edge on ticks and votes samples
// MID-1..MID+1 of each bit. It pulses done after the stop bit with the data and
// a framing flag. It also reports a line that has been idle for one character
// time. Assumes tick is a single-cycle pulse.
module uart_lw_rx
    import uart_lw_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int OVS    = 16,
    parameter int MID    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              en,
    input  logic              nine,
    input  logic              line,
    input  logic              idle_clr,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              ferr,
    output logic              idle_pulse
);
    localparam int CNT_W    = $clog2(OVS);
    localparam int BIT_W    = $clog2(DATA_W + 2);
    localparam int IDLE_MAX = (DATA_W + 2) * OVS;
    localparam int IDLE_W   = $clog2(IDLE_MAX + 1);

    rx_state_t         state;
    logic              prev;
    logic [CNT_W-1:0]  tcnt;
    logic [CNT_W-1:0]  idx;
    logic [BIT_W-1:0]  bit_idx;
    logic [BIT_W-1:0]  bit_last;
    logic              s_a, s_b, vote, nine_q;
    logic [IDLE_W-1:0] idle_cnt;
    logic [IDLE_W-1:0] idle_limit;

    // Sample position, voted bit and frame/idle lengths.
    always_comb begin
        idx        = tcnt + 1'b1;
        vote       = maj3(s_a, s_b, line);
        bit_last   = nine_q ? BIT_W'(DATA_W + 1) : BIT_W'(DATA_W);
        idle_limit = nine ? IDLE_W'(IDLE_MAX) : IDLE_W'(IDLE_MAX - OVS);
    end

    // Frame state machine: start detection, bit sampling, stop check.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            state   <= RX_IDLE;
            prev    <= 1'b1;
            tcnt    <= '0;
            bit_idx <= '0;
            s_a     <= 1'b1;
            s_b     <= 1'b1;
            nine_q  <= 1'b0;
            data    <= '0;
            done    <= 1'b0;
            ferr    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                prev <= line;
                case (state)
                    RX_IDLE: begin
                        if (prev && !line) begin
                            state   <= RX_RECV;
                            tcnt    <= '0;
                            bit_idx <= '0;
                            nine_q  <= nine;
                        end
                    end
                    RX_RECV: begin
                        tcnt <= idx;
                        if (tcnt == CNT_W'(OVS - 1)) begin
                            bit_idx <= bit_idx + 1'b1;
                        end
                        if (idx == CNT_W'(MID - 1)) s_a <= line;
                        if (idx == CNT_W'(MID))     s_b <= line;
                        if (idx == CNT_W'(MID + 1)) begin
                            if (bit_idx == '0) begin
                                data <= '0;
                                if (vote) state <= RX_IDLE;
                            end else if (bit_idx == bit_last) begin
                                done  <= 1'b1;
                                ferr  <= !vote;
                                state <= RX_IDLE;
                            end else begin
                                data[bit_idx - 1'b1] <= vote;
                            end
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    // Count consecutive high ticks and flag one full character of idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || idle_clr) begin
            idle_cnt   <= '0;
            idle_pulse <= 1'b0;
        end else begin
            idle_pulse <= 1'b0;
            if (tick) begin
                if (!line) begin
                    idle_cnt <= '0;
                end else if (idle_cnt < idle_limit) begin
                    idle_cnt <= idle_cnt + 1'b1;
                    if (idle_cnt == idle_limit - 1'b1) idle_pulse <= 1'b1;
                end
            end
        end
    end

    // R4: a completed frame is reported for exactly one cycle.
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: the bit index never passes the stop bit position.
    p_bit_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_RECV) |-> (bit_idx <= BIT_W'(DATA_W + 1)));

endmodule

// File: rtl/uart_lw_wake.sv
// Module: standby control. Gates completed frames onto the outputs and leaves
// standby on idle line or on an address mark, as chosen by addr_mode.
// A sleep request takes priority over a frame completing in the same cycle.
module uart_lw_wake #(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nine,
    input  logic              addr_mode,
    input  logic              sleep_req,
    input  logic              idle_pulse,
    input  logic              done,
    input  logic [DATA_W-1:0] data,
    input  logic              ferr,
    output logic              valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_ferr,
    output logic              standby
);
    logic mark;

    // Address mark is the top data bit of the active frame length.
    always_comb mark = nine ? data[DATA_W-1] : data[DATA_W-2];

    // Track standby and deliver or drop each completed frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid    <= 1'b0;
            out_data <= '0;
            out_ferr <= 1'b0;
            standby  <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (sleep_req) begin
                standby <= 1'b1;
            end else if (done) begin
                if (!standby || (addr_mode && mark)) begin
                    valid    <= 1'b1;
                    out_data <= data;
                    out_ferr <= ferr;
                    standby  <= 1'b0;
                end
            end else if (standby && !addr_mode && idle_pulse) begin
                standby <= 1'b0;
            end
        end
    end

    // R9: no character is presented while in standby.
    p_quiet_standby_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> !standby);

    // R9: a sleep request always enters standby.
    p_sleep_enters_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |=> standby);

    // R11: a marked frame in address mode wakes and is delivered.
    p_addr_wake_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && standby && addr_mode && mark && !sleep_req) |=> (valid && !standby));

endmodule

// File: rtl/uart_loopwake.sv
// Module: top of the transceiver. Selects the receiver source (pin,
// internal transmit line or single-wire pad) and controls the pad enable.
// Loop routing is active only when both directions are enabled; otherwise
// the receiver sees an idle line in loop mode.
module uart_loopwake #(
    parameter int DATA_W = 9,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              loop_en,
    input  logic              rx_src_ext,
    input  logic              nine_bit,
    input  logic              wake_on_mark,
    input  logic              rx_sleep_req,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              tx_pin,
    output logic              tx_oe,
    input  logic              wire_in,
    input  logic              rx_pin,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_ferr,
    output logic              rx_standby
);
    localparam int MID = OVS / 2;

    logic              tx_line, tx_busy, rx_in;
    logic              fr_done, fr_ferr, idle_pulse;
    logic [DATA_W-1:0] fr_data;

    uart_lw_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (baud_tick),
        .en    (tx_en),
        .nine  (nine_bit),
        .data  (tx_data),
        .valid (tx_valid),
        .ready (tx_ready),
        .line  (tx_line),
        .busy  (tx_busy)
    );

    // Receiver source selection and pad driver enable.
    always_comb begin
        if (!loop_en)              rx_in = rx_pin;
        else if (!(tx_en && rx_en)) rx_in = 1'b1;
        else if (rx_src_ext)       rx_in = wire_in;
        else                       rx_in = tx_line;
        tx_pin = tx_line;
        tx_oe  = !(loop_en && rx_src_ext) || tx_busy;
    end

    uart_lw_rx #(.DATA_W(DATA_W), .OVS(OVS), .MID(MID)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (baud_tick),
        .en         (rx_en),
        .nine       (nine_bit),
        .line       (rx_in),
        .idle_clr   (rx_sleep_req),
        .done       (fr_done),
        .data       (fr_data),
        .ferr       (fr_ferr),
        .idle_pulse (idle_pulse)
    );

    uart_lw_wake #(.DATA_W(DATA_W)) u_wake (
        .clk        (clk),
        .rst_n      (rst_n),
        .nine       (nine_bit),
        .addr_mode  (wake_on_mark),
        .sleep_req  (rx_sleep_req),
        .idle_pulse (idle_pulse),
        .done       (fr_done),
        .data       (fr_data),
        .ferr       (fr_ferr),
        .valid      (rx_valid),
        .out_data   (rx_data),
        .out_ferr   (rx_ferr),
        .standby    (rx_standby)
    );

    // R7: in single-wire mode the pad is released while nothing is sent.
    p_oe_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_en && rx_src_ext && tx_ready) |-> !tx_oe);

endmodule

// File: tb/test_uart_loopwake.sv
// Scoreboard bench: the drivers queue expected characters, and a monitor
// pops and compares them on each rx_valid pulse.
module test_uart_loopwake;
    localparam int CLK_PERIOD = 10;
    localparam int BIT_CLK    = 32;   // 16 ticks, one tick every 2 clocks

    logic       clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0;
    logic       tx_en = 0, rx_en = 0, loop_en = 0, rx_src_ext = 0;
    logic       nine_bit = 0, wake_on_mark = 0, rx_sleep_req = 0;
    logic [8:0] tx_data = '0;
    logic       tx_valid = 0, wire_in = 1, rx_pin = 1;
    logic       tx_ready, tx_pin, tx_oe, rx_valid, rx_ferr, rx_standby;
    logic [8:0] rx_data;

    int checks = 0, errors = 0, valid_seen = 0;
    logic [9:0] exp_q[$];
    string      tag_q[$];

    uart_loopwake i_uart_loopwake (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
        .rx_en(rx_en), .loop_en(loop_en), .rx_src_ext(rx_src_ext),
        .nine_bit(nine_bit), .wake_on_mark(wake_on_mark),
        .rx_sleep_req(rx_sleep_req), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_pin(tx_pin), .tx_oe(tx_oe), .wire_in(wire_in),
        .rx_pin(rx_pin), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_ferr(rx_ferr), .rx_standby(rx_standby)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        forever begin
            @(negedge clk);
            baud_tick = ~baud_tick;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_rx(input logic [8:0] d, input logic fe, input string tag);
        exp_q.push_back({fe, d});
        tag_q.push_back(tag);
    endtask

    // Monitor: compare every delivered character against the queue.
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            valid_seen++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 unexpected rx_valid", {rx_ferr, rx_data}, 0);
            end else begin
                logic [9:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({rx_ferr, rx_data} === e, t, {rx_ferr, rx_data}, e);
            end
        end
    end

    task automatic put_bit(input logic b, input bit to_wire);
        if (to_wire) wire_in = b; else rx_pin = b;
        repeat (BIT_CLK) @(negedge clk);
    endtask

    task automatic drive_frame(input logic [8:0] d, input bit nine, input bit stopv,
                               input bit to_wire);
        int nb;
        nb = nine ? 9 : 8;
        put_bit(1'b0, to_wire);
        for (int i = 0; i < nb; i++) put_bit(d[i], to_wire);
        put_bit(stopv, to_wire);
        if (!stopv) put_bit(1'b1, to_wire);
    endtask

    // Send a word and check the serial waveform at mid-bit points.
    task automatic tx_send_check(input logic [8:0] d, input bit nine, input string tag,
                                 input bit want_oe);
        int nb;
        logic [8:0] got, expv;
        nb = nine ? 9 : 8;
        expv = nine ? d : {1'b0, d[7:0]};
        got = '0;
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        tx_data = d;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        repeat (15) @(negedge clk);
        chk(tx_pin == 1'b0, {tag, " start bit"}, tx_pin, 0);
        chk(tx_ready == 1'b0, "R2 ready low while sending", tx_ready, 0);
        if (want_oe) chk(tx_oe == 1'b1, "R7 tx_oe high while sending", tx_oe, 1);
        for (int i = 0; i < nb; i++) begin
            repeat (BIT_CLK) @(negedge clk);
            got[i] = tx_pin;
        end
        chk(got == expv, {tag, " data bits"}, got, expv);
        repeat (BIT_CLK) @(negedge clk);
        chk(tx_pin == 1'b1, {tag, " stop bit"}, tx_pin, 1);
        repeat (BIT_CLK) @(negedge clk);
    endtask

    task automatic sleep_pulse();
        @(negedge clk);
        rx_sleep_req = 1'b1;
        @(negedge clk);
        rx_sleep_req = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int vs;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(tx_pin == 1'b1, "R1 tx_pin idle", tx_pin, 1);
        chk(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
        chk(rx_ferr == 1'b0, "R1 rx_ferr", rx_ferr, 0);
        chk(rx_standby == 1'b0, "R1 rx_standby", rx_standby, 0);
        chk(tx_ready == 1'b0, "R1 tx_ready with tx disabled", tx_ready, 0);
        tx_en = 1'b1;
        rx_en = 1'b1;
        repeat (4) @(negedge clk);

        // R4: 8-bit reception
        expect_rx(9'h0A5, 1'b0, "R4 rx 8-bit A5");
        drive_frame(9'h0A5, 0, 1, 0);
        expect_rx(9'h03C, 1'b0, "R4 rx 8-bit 3C");
        drive_frame(9'h03C, 0, 1, 0);
        // R3: 9-bit reception, mode bit ignored bit 8 in 8-bit
        nine_bit = 1'b1;
        expect_rx(9'h1A5, 1'b0, "R3 rx 9-bit 1A5");
        drive_frame(9'h1A5, 1, 1, 0);
        expect_rx(9'h0FF, 1'b0, "R3 rx 9-bit 0FF");
        drive_frame(9'h0FF, 1, 1, 0);
        nine_bit = 1'b0;
        // R5: framing error
        expect_rx(9'h081, 1'b1, "R5 framing error");
        drive_frame(9'h081, 0, 0, 0);
        repeat (BIT_CLK * 2) @(negedge clk);

        // R2 / R3: transmit waveforms
        tx_send_check(9'h1C6, 0, "R2 tx 8-bit", 0);
        nine_bit = 1'b1;
        tx_send_check(9'h13C, 1, "R3 tx 9-bit", 0);
        nine_bit = 1'b0;

        // R6: internal loop, rx_pin held low and ignored
        loop_en = 1'b1;
        rx_pin = 1'b0;
        repeat (BIT_CLK) @(negedge clk);
        expect_rx(9'h05A, 1'b0, "R6 internal loop");
        tx_send_check(9'h05A, 0, "R6 loop tx", 0);
        repeat (BIT_CLK * 2) @(negedge clk);

        // R8: loop without transmitter enable receives nothing
        tx_en = 1'b0;
        vs = valid_seen;
        drive_frame(9'h033, 0, 1, 0);
        rx_pin = 1'b1;
        drive_frame(9'h033, 0, 1, 0);
        repeat (BIT_CLK * 2) @(negedge clk);
        chk(valid_seen == vs, "R8 no reception in loop with tx off", valid_seen - vs, 0);
        tx_en = 1'b1;

        // R7: single-wire mode from wire_in
        rx_src_ext = 1'b1;
        repeat (BIT_CLK) @(negedge clk);
        chk(tx_oe == 1'b0, "R7 tx_oe released when idle", tx_oe, 0);
        expect_rx(9'h0C3, 1'b0, "R7 single-wire rx");
        drive_frame(9'h0C3, 0, 1, 1);
        tx_send_check(9'h011, 0, "R7 single-wire tx", 1);
        loop_en = 1'b0;
        rx_src_ext = 1'b0;
        repeat (BIT_CLK * 2) @(negedge clk);

        // R9 / R10: idle-line wakeup
        wake_on_mark = 1'b0;
        sleep_pulse();
        chk(rx_standby == 1'b1, "R9 standby set", rx_standby, 1);
        drive_frame(9'h0F0, 0, 1, 0);
        chk(rx_standby == 1'b1, "R10 still asleep before idle time", rx_standby, 1);
        repeat (BIT_CLK * 12) @(negedge clk);
        chk(rx_standby == 1'b0, "R10 woken by idle line", rx_standby, 0);
        expect_rx(9'h077, 1'b0, "R10 rx after idle wake");
        drive_frame(9'h077, 0, 1, 0);

        // R11: address-mark wakeup
        wake_on_mark = 1'b1;
        sleep_pulse();
        drive_frame(9'h012, 0, 1, 0);
        repeat (BIT_CLK * 12) @(negedge clk);
        chk(rx_standby == 1'b1, "R11 idle ignored in mark mode", rx_standby, 1);
        expect_rx(9'h085, 1'b0, "R11 address char delivered");
        drive_frame(9'h085, 0, 1, 0);
        chk(rx_standby == 1'b0, "R11 standby cleared by mark", rx_standby, 0);
        // R11: nine-bit mark uses bit 8
        nine_bit = 1'b1;
        sleep_pulse();
        drive_frame(9'h0FF, 1, 1, 0);
        chk(rx_standby == 1'b1, "R11 bit 7 not a mark in 9-bit", rx_standby, 1);
        expect_rx(9'h101, 1'b0, "R11 9-bit address char");
        drive_frame(9'h101, 1, 1, 0);
        chk(rx_standby == 1'b0, "R11 9-bit mark wakes", rx_standby, 0);

        repeat (BIT_CLK * 2) @(negedge clk);
        chk(exp_q.size() == 0, "R4 all expected characters seen", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule